// File: doc/BRIEF.md
# Strobed Configuration Register Port with Broadcast Write

This block is the configuration slave of a routing switch. It holds three sets of 7-bit registers: one set of per-channel control settings and two banks of routing addresses, 68 entries each. An external controller reaches them over a narrow parallel bus. That bus carries a channel address, a bidirectional data bus, an active-low chip select, a read/write line, a line that chooses the control set over the routing banks, a bank-select line and a write strobe. The current contents of all three sets appear as flat output vectors, so the switch datapath can use them directly.

The write strobe comes from an asynchronous controller. The block brings it into the system clock domain through a two-flop synchroniser and then detects its rising edge. Each rising edge produces exactly one write, taken from the channel address and data that are stable on the bus at that moment. Reads are combinational. While the chip is selected and the read/write line asks for a read, the addressed register is driven onto the data bus. At all other times the block leaves the bus floating. The all-ones channel address is reserved for broadcast: a write to it loads every entry of the selected set in one clock.

Top module: `cfg_strobe_regs`

## Requirements
- R1: Reset clears every register of all three sets to 0. All reads after reset return 0.
- R2: A write (cs_n=0, rd_wr=0) takes effect on the rising edge of wr_stb. After the synchroniser, the register is updated on the third system clock edge after the strobe rises.
- R3: With ctl_sel=1, reads and writes reach the control set, whatever bank_sel is.
- R4: With ctl_sel=0, bank_sel=0 selects routing bank 0 and bank_sel=1 selects routing bank 1. A write to one bank leaves the other bank and the control set unchanged.
- R5: With cs_n=0 and rd_wr=1, data_io carries the register picked by ch_addr (bit 6 is the MSB) in the selected set. Channel addresses 68 to 127 read as 0.
- R6: With cs_n=1, the block leaves data_io undriven and ignores any strobe.
- R7: With cs_n=0 and rd_wr=0, the block leaves data_io undriven, so the controller can drive it.
- R8: A write to ch_addr 7'b1111111 loads the same data into all 68 entries of the selected set only.
- R9: Writes to channel addresses 68 to 126 change no register.
- R10: A strobe held high produces one write only. Data that changes while the strobe stays high is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_addr | input | 7 | Channel address; 127 means broadcast on write |
| data_io | inout | 7 | Bidirectional register data |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ctl_sel | input | 1 | 1 = control set, 0 = routing bank |
| bank_sel | input | 1 | Routing bank accessed when ctl_sel=0 |
| wr_stb | input | 1 | Asynchronous write strobe, rising edge active |
| ctrl_q | output | 476 | Control set, entry i at bits [7i+6:7i] |
| route0_q | output | 476 | Routing bank 0, same packing |
| route1_q | output | 476 | Routing bank 1, same packing |

## Verification
The bench writes every entry of each set with a distinct value derived from the set and the address. Before filling the next set, it reads back the sets not yet written, so a bank-select or set-decode error shows up as a stray non-zero value. It writes to the out-of-range addresses and with chip select high, then reads everything back. A design that wrapped an address or ignored the chip select would show a corrupted entry. The bench broadcasts to one bank and checks the other two sets: a decoder that let the broadcast cross sets would overwrite them. It also changes the data while the strobe is held high. A level-sensitive write, in place of an edge-triggered one, would store the second value. To catch the block driving the bus when it must not, the bench drives zeros against a non-zero register and checks that the zeros come back unchanged.

// File: rtl/cfg_strobe_regs.sv
module cfg_strobe_regs #(
  parameter int NCH = 68,
  parameter int W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     ch_addr,
  inout  wire  [W-1:0]     data_io,
  input  logic             cs_n,
  input  logic             rd_wr,
  input  logic             ctl_sel,
  input  logic             bank_sel,
  input  logic             wr_stb,
  output logic [NCH*W-1:0] ctrl_q,
  output logic [NCH*W-1:0] route0_q,
  output logic [NCH*W-1:0] route1_q
);
  localparam logic [W-1:0] BCAST = '1;
  localparam logic [W-1:0] LAST  = W'(NCH - 1);

  logic [2:0]   stb_sync;
  logic         stb_rise, wr_go;
  logic [1:0]   set_idx;
  logic [W-1:0] rd_val;
  logic [W-1:0] regs [3][NCH];

  always_ff @(posedge clk) begin
    if (rst) stb_sync <= '0;
    else     stb_sync <= {stb_sync[1:0], wr_stb};
  end

  assign stb_rise = stb_sync[1] & ~stb_sync[2];
  assign wr_go    = stb_rise & ~cs_n & ~rd_wr;
  assign set_idx  = ctl_sel ? 2'd2 : {1'b0, bank_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < NCH; i++)
          regs[s][i] <= '0;
    end else if (wr_go) begin
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < NCH; i++)
          if (2'(s) == set_idx && (ch_addr == BCAST || ch_addr == W'(i)))
            regs[s][i] <= data_io;
    end
  end

  assign rd_val  = (ch_addr <= LAST) ? regs[set_idx][ch_addr] : '0;
  assign data_io = (!cs_n && rd_wr) ? rd_val : 'z;

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign route0_q[g*W +: W] = regs[0][g];
    assign route1_q[g*W +: W] = regs[1][g];
    assign ctrl_q[g*W +: W]   = regs[2][g];
  end

  p_one_write_per_edge_r10: assert property (@(posedge clk) disable iff (rst)
    stb_rise |=> !stb_rise);

  p_deselected_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && cs_n) |=> ($stable(ctrl_q) && $stable(route0_q) && $stable(route1_q)));

  p_read_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && rd_wr) |=> ($stable(ctrl_q) && $stable(route0_q) && $stable(route1_q)));

  p_bank0_isolated_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_sel && !bank_sel) |=> ($stable(route1_q) && $stable(ctrl_q)));

  p_ctrl_write_keeps_banks_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_sel |=> ($stable(route0_q) && $stable(route1_q)));

  p_high_addr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && ch_addr > LAST && ch_addr != BCAST)
      |=> ($stable(ctrl_q) && $stable(route0_q) && $stable(route1_q)));
endmodule

// File: tb/tb_cfg_strobe_regs.sv
module tb_cfg_strobe_regs;
  localparam int NCH = 68;
  localparam int W   = 7;

  logic clk = 0, rst = 1;
  logic [W-1:0] ch_addr = '0;
  logic cs_n = 1, rd_wr = 1, ctl_sel = 0, bank_sel = 0, wr_stb = 0;
  logic tb_oe = 0;
  logic [W-1:0] tb_d = '0;
  tri   [W-1:0] bus;
  logic [NCH*W-1:0] ctrl_q, route0_q, route1_q;

  int checks = 0, errors = 0;
  logic [W-1:0] model [3][128];

  assign bus = tb_oe ? tb_d : 'z;

  cfg_strobe_regs #(.NCH(NCH), .W(W)) dut (
    .clk(clk), .rst(rst), .ch_addr(ch_addr), .data_io(bus), .cs_n(cs_n),
    .rd_wr(rd_wr), .ctl_sel(ctl_sel), .bank_sel(bank_sel), .wr_stb(wr_stb),
    .ctrl_q(ctrl_q), .route0_q(route0_q), .route1_q(route1_q));

  always #5 clk = ~clk;

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pick(input int s);
    ctl_sel  = (s == 2);
    bank_sel = (s == 1);
  endtask

  task automatic wr(input int s, input int a, input logic [W-1:0] d, input logic csn);
    @(negedge clk);
    pick(s); ch_addr = W'(a); cs_n = csn; rd_wr = 0; tb_d = d; tb_oe = 1;
    @(negedge clk); wr_stb = 1;
    repeat (4) @(negedge clk);
    wr_stb = 0;
    repeat (3) @(negedge clk);
    tb_oe = 0; rd_wr = 1; cs_n = 1;
    if (!csn && a <= NCH - 1) model[s][a] = d;
    if (!csn && a == 127) for (int i = 0; i < NCH; i++) model[s][i] = d;
  endtask

  task automatic rd(input string req, input int s, input int a);
    @(negedge clk);
    pick(s); ch_addr = W'(a); cs_n = 0; rd_wr = 1; tb_oe = 0;
    #1;
    chk(req, bus, (a < NCH) ? model[s][a] : '0);
    cs_n = 1;
  endtask

  task automatic rd_set(input string req, input int s);
    for (int a = 0; a < 128; a++) rd(req, s, a);
  endtask

  initial begin
    for (int s = 0; s < 3; s++) for (int a = 0; a < 128; a++) model[s][a] = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state, R5 high addresses read 0
    for (int s = 0; s < 3; s++) rd_set("R1", s);

    // R4 bank 0 fill leaves bank 1 and control untouched
    for (int a = 0; a < NCH; a++) wr(0, a, W'((a * 5 + 3) & 127), 0);
    rd_set("R4", 1);
    rd_set("R3", 2);
    for (int a = 0; a < NCH; a++) wr(1, a, W'((a * 11 + 40) & 127), 0);
    rd_set("R3", 2);
    for (int a = 0; a < NCH; a++) wr(2, a, W'((a * 7 + 91) & 127), 0);
    // R2 R5 full readback
    rd_set("R2", 0);
    rd_set("R5", 1);
    rd_set("R3", 2);

    // R9 out-of-range writes
    for (int s = 0; s < 3; s++) begin
      wr(s, 68, 7'h11, 0);
      wr(s, 100, 7'h22, 0);
      wr(s, 126, 7'h33, 0);
    end
    for (int s = 0; s < 3; s++) rd_set("R9", s);

    // R6 deselected write ignored
    wr(2, 5, 7'h55, 1);
    wr(0, 0, 7'h55, 1);
    rd("R6", 2, 5);
    rd("R6", 0, 0);

    // R6 bus undriven when deselected: bench drives 0 against nonzero register
    @(negedge clk);
    pick(0); ch_addr = 7'd1; cs_n = 1; rd_wr = 1; tb_d = '0; tb_oe = 1;
    #1 chk("R6", bus, '0);
    // R7 bus undriven during write mode
    cs_n = 0; rd_wr = 0; tb_d = '0;
    #1 chk("R7", bus, '0);
    tb_oe = 0; cs_n = 1; rd_wr = 1;

    // R8 broadcast to bank 1, then control
    wr(1, 127, 7'h2A, 0);
    rd_set("R8", 1);
    rd_set("R8", 0);
    rd_set("R8", 2);
    wr(2, 127, 7'h7F, 0);
    rd_set("R8", 2);
    rd_set("R8", 1);

    // R10 data change while strobe held high
    @(negedge clk);
    pick(0); ch_addr = 7'd9; cs_n = 0; rd_wr = 0; tb_d = 7'h0C; tb_oe = 1;
    @(negedge clk); wr_stb = 1;
    repeat (4) @(negedge clk);
    tb_d = 7'h63;
    repeat (4) @(negedge clk);
    wr_stb = 0;
    repeat (3) @(negedge clk);
    tb_oe = 0; rd_wr = 1; cs_n = 1;
    model[0][9] = 7'h0C;
    rd("R10", 0, 9);

    // R2 latency: register unchanged two edges after strobe, updated on third
    @(negedge clk);
    pick(0); ch_addr = 7'd20; cs_n = 0; rd_wr = 0; tb_d = 7'h44; tb_oe = 1;
    @(negedge clk); wr_stb = 1;
    @(negedge clk); @(negedge clk);
    chk("R2", route0_q[20*W +: W], W'((20 * 5 + 3) & 127));
    @(negedge clk);
    chk("R2", route0_q[20*W +: W], 7'h44);
    wr_stb = 0;
    repeat (3) @(negedge clk);
    tb_oe = 0; rd_wr = 1; cs_n = 1;
    model[0][20] = 7'h44;

    // R1 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int s = 0; s < 3; s++) for (int a = 0; a < 128; a++) model[s][a] = '0;
    for (int s = 0; s < 3; s++) rd_set("R1", s);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule